// File: doc/BRIEF.md
# Dual-Slice 16-bit ALU with Operand Byte Swap

This block is the arithmetic and logic stage of a small 16-bit processor whose register file can be read as whole words or as single bytes. The datapath is made of two identical 8-bit slices. For word work the lower slice's carry feeds the upper slice, so the two act as one 16-bit adder. For byte work only the lower slice computes, and the upper slice passes a byte of operand A through unchanged, so the result is always a full 16-bit word that can be written back whole.

Each operand first passes through its own byte-exchange switch. The switch is driven by the low bit of the register number that supplied the operand. In byte mode it decides which half of the register reaches the lower slice. In word mode it selects big- or little-endian byte order. The block is purely combinational. It returns a result word, a condition-code byte and a strobe that says whether the flags should be stored.

Top module: `alu16_lanes`

## Requirements
- R1: When `swapA` is 1, the two bytes of `opA` are exchanged before any use; when 0, `opA` is used as is. `swapB` does the same for `opB`. Every result and flag below is defined on these exchanged operands, written A and B.
- R2: Opcode 1 (ADD) yields A+B and opcode 2 (ADC) yields A+B+`carryIn`. In word mode the carry ripples from the lower slice into the upper slice, and C is the carry out of bit 15.
- R3: Opcode 3 (SUB) yields A−B and opcode 4 (SBC) yields A−B−`carryIn`. C is 1 when a borrow occurs, so SBC treats `carryIn` as the incoming borrow.
- R4: Opcodes 5 (AND), 6 (OR) and 7 (XOR) give the bitwise result, clear V and H, and copy `carryIn` to C.
- R5: Opcode 8 (BIT) returns A unchanged on `result`. N and Z are taken from A AND B, V and H are 0, C equals `carryIn`, and `flagWe` is 1.
- R6: When `wordMode` is 0, the operation uses only the low bytes of A and B. `result[7:0]` holds the byte result and `result[15:8]` holds the upper byte of A, passed through unchanged.
- R7: When `wordMode` is 0, N is bit 7 of the byte value, Z is set when that byte is zero, and V and C come from bit 7 of the lower slice.
- R8: When `wordMode` is 1, N is bit 15, Z covers all 16 bits, and V and C come from the upper slice. Signed overflow is the usual two's-complement rule.
- R9: H is the carry out of bit 3 for ADD and ADC in either size. It is 0 for every other opcode.
- R10: The `flags` byte places H at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. Bits 7 to 5 read 0.
- R11: Opcode 0 (pass) and the unused codes 9 to 15 drive B on `result`, hold `flags` at 0 and drive `flagWe` low. All defined opcodes 1 to 8 drive `flagWe` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand, read as a register word |
| opB | input | 16 | Second operand, read as a register word |
| opCode | input | 4 | Operation select: 0 pass, 1 ADD, 2 ADC, 3 SUB, 4 SBC, 5 AND, 6 OR, 7 XOR, 8 BIT |
| wordMode | input | 1 | 1 selects a 16-bit operation, 0 selects an 8-bit operation |
| swapA | input | 1 | Register-number LSB for A; exchanges the bytes of A |
| swapB | input | 1 | Register-number LSB for B; exchanges the bytes of B |
| carryIn | input | 1 | Stored C flag, used as carry or borrow |
| result | output | 16 | Result word |
| flags | output | 8 | Condition-code byte {3'b0,H,N,Z,V,C} |
| flagWe | output | 1 | High when the condition codes should be stored |

## Verification
Every output is a function of the current inputs only, so each result is due in the same clock period as its stimulus, with zero register delay. The driver changes the inputs just after a rising edge and queues the expected result word, flag byte and write strobe computed from the requirements. The monitor pops and compares that entry at the next falling edge, half a period later, when the combinational paths have settled and before the driver moves again. Directed vectors cover carries across the byte boundary, overflow edges, borrow chains, each swap combination in both sizes, and the unused opcodes. A long pseudo-random stream then mixes all controls.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADC  = 4'd2,
    OP_SUB  = 4'd3,
    OP_SBC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_BIT  = 4'd8
  } aluOp_e;

  typedef enum logic [1:0] {
    FN_ARITH = 2'd0,
    FN_AND   = 2'd1,
    FN_OR    = 2'd2,
    FN_XOR   = 2'd3
  } sliceFn_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    sliceFn_e fn;
    logic     invertB;     // subtract: feed ~B
    logic     carryForce;  // force a 1 into the chain
    logic     carryFromIn; // take the stored carry into the chain
    logic     carryInvert; // stored carry is a borrow
    logic     arith;       // V/C come from the adder
    logic     halfValid;   // H meaningful (add forms only)
    logic     passB;       // result = B, no flags
    logic     keepA;       // result = A (bit test)
    logic     flagWe;
  } aluCtrl_t;

  localparam int CC_W   = 8;
  localparam int CC_C   = 0;
  localparam int CC_V   = 1;
  localparam int CC_Z   = 2;
  localparam int CC_N   = 3;
  localparam int CC_H   = 4;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{fn: FN_ARITH, invertB: 1'b0, carryForce: 1'b0, carryFromIn: 1'b0,
             carryInvert: 1'b0, arith: 1'b0, halfValid: 1'b0, passB: 1'b1,
             keepA: 1'b0, flagWe: 1'b0};
    case (opCode)
      OP_ADD: begin
        ctrl.passB = 1'b0; ctrl.arith = 1'b1; ctrl.halfValid = 1'b1; ctrl.flagWe = 1'b1;
      end
      OP_ADC: begin
        ctrl.passB = 1'b0; ctrl.arith = 1'b1; ctrl.halfValid = 1'b1; ctrl.flagWe = 1'b1;
        ctrl.carryFromIn = 1'b1;
      end
      OP_SUB: begin
        ctrl.passB = 1'b0; ctrl.arith = 1'b1; ctrl.flagWe = 1'b1;
        ctrl.invertB = 1'b1; ctrl.carryForce = 1'b1;
      end
      OP_SBC: begin
        ctrl.passB = 1'b0; ctrl.arith = 1'b1; ctrl.flagWe = 1'b1;
        ctrl.invertB = 1'b1; ctrl.carryFromIn = 1'b1; ctrl.carryInvert = 1'b1;
      end
      OP_AND: begin
        ctrl.passB = 1'b0; ctrl.fn = FN_AND; ctrl.flagWe = 1'b1;
      end
      OP_OR: begin
        ctrl.passB = 1'b0; ctrl.fn = FN_OR; ctrl.flagWe = 1'b1;
      end
      OP_XOR: begin
        ctrl.passB = 1'b0; ctrl.fn = FN_XOR; ctrl.flagWe = 1'b1;
      end
      OP_BIT: begin
        ctrl.passB = 1'b0; ctrl.fn = FN_AND; ctrl.keepA = 1'b1; ctrl.flagWe = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu16_slice.sv
module alu16_slice
  import alu16_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] aIn,
  input  logic [LANE_W-1:0] bIn,
  input  sliceFn_e          fn,
  input  logic              invertB,
  input  logic              cin,
  output logic [LANE_W-1:0] value,
  output logic              cout,
  output logic              halfCarry,
  output logic              ovf
);

  localparam int NIB_W = LANE_W / 2;

  logic [LANE_W-1:0] bEff;
  logic [LANE_W:0]   sum;
  logic [NIB_W:0]    nibSum;

  always_comb begin
    bEff   = invertB ? ~bIn : bIn;
    sum    = {1'b0, aIn} + {1'b0, bEff} + {{LANE_W{1'b0}}, cin};
    nibSum = {1'b0, aIn[NIB_W-1:0]} + {1'b0, bEff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    cout      = sum[LANE_W];
    halfCarry = nibSum[NIB_W];
    ovf       = (aIn[LANE_W-1] == bEff[LANE_W-1]) && (sum[LANE_W-1] != aIn[LANE_W-1]);
    case (fn)
      FN_AND:  value = aIn & bIn;
      FN_OR:   value = aIn | bIn;
      FN_XOR:  value = aIn ^ bIn;
      default: value = sum[LANE_W-1:0];
    endcase
  end

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [2*LANE_W-1:0] opA,
  input  logic [2*LANE_W-1:0] opB,
  input  logic                wordMode,
  input  logic                swapA,
  input  logic                swapB,
  input  logic                carryIn,
  input  aluCtrl_t            ctrl,
  output logic [2*LANE_W-1:0] result,
  output logic [CC_W-1:0]     flags
);

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] swA, swB, sliceVal;
  logic [LANES:0]    chain;
  logic [LANES-1:0]  sliceOvf, sliceHalf;
  logic              cinLow;

  assign swA = swapA ? {opA[LANE_W-1:0], opA[DATA_W-1:LANE_W]} : opA;
  assign swB = swapB ? {opB[LANE_W-1:0], opB[DATA_W-1:LANE_W]} : opB;

  assign cinLow   = ctrl.carryForce | (ctrl.carryFromIn & (carryIn ^ ctrl.carryInvert));
  assign chain[0] = cinLow;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    alu16_slice #(.LANE_W(LANE_W)) slice_i (
      .aIn      (swA[g*LANE_W +: LANE_W]),
      .bIn      (swB[g*LANE_W +: LANE_W]),
      .fn       (ctrl.fn),
      .invertB  (ctrl.invertB),
      .cin      (chain[g]),
      .value    (sliceVal[g*LANE_W +: LANE_W]),
      .cout     (chain[g+1]),
      .halfCarry(sliceHalf[g]),
      .ovf      (sliceOvf[g])
    );
  end

  logic topMsb, topCout, topOvf, zeroVal;
  logic fN, fZ, fV, fC, fH;

  always_comb begin
    if (wordMode) begin
      topMsb  = sliceVal[DATA_W-1];
      topCout = chain[LANES];
      topOvf  = sliceOvf[LANES-1];
      zeroVal = (sliceVal == '0);
    end else begin
      topMsb  = sliceVal[LANE_W-1];
      topCout = chain[1];
      topOvf  = sliceOvf[0];
      zeroVal = (sliceVal[LANE_W-1:0] == '0);
    end
    fN = topMsb;
    fZ = zeroVal;
    fV = ctrl.arith & topOvf;
    fC = ctrl.arith ? (topCout ^ ctrl.invertB) : carryIn;
    fH = ctrl.halfValid & sliceHalf[0];

    flags = '0;
    if (ctrl.flagWe) begin
      flags[CC_H] = fH;
      flags[CC_N] = fN;
      flags[CC_Z] = fZ;
      flags[CC_V] = fV;
      flags[CC_C] = fC;
    end

    if (ctrl.passB)      result = swB;
    else if (ctrl.keepA) result = swA;
    else if (wordMode)   result = sliceVal;
    else                 result = {swA[DATA_W-1:LANE_W], sliceVal[LANE_W-1:0]};
  end

  logic [DATA_W:0] fullSum;
  always_comb begin
    fullSum = {1'b0, swA} + {1'b0, (ctrl.invertB ? ~swB : swB)} + {{DATA_W{1'b0}}, cinLow};
    // R2
    if (ctrl.arith && wordMode)
      chain_link_chk: assert ({chain[LANES], sliceVal} == fullSum)
        else $error("slice carry chain disagrees with a full-width add");
    // R10
    zn_excl_chk: assert (!(flags[CC_Z] && flags[CC_N]))
      else $error("Z and N both set");
  end

endmodule

// File: rtl/alu16_lanes.sv
module alu16_lanes
  import alu16_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [2*LANE_W-1:0] opA,
  input  logic [2*LANE_W-1:0] opB,
  input  logic [3:0]          opCode,
  input  logic                wordMode,
  input  logic                swapA,
  input  logic                swapB,
  input  logic                carryIn,
  output logic [2*LANE_W-1:0] result,
  output logic [CC_W-1:0]     flags,
  output logic                flagWe
);

  localparam int DATA_W = 2 * LANE_W;

  aluCtrl_t ctrl;

  alu16_ctrl ctrl_i (
    .opCode(opCode),
    .ctrl  (ctrl)
  );

  alu16_datapath #(.LANE_W(LANE_W)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .wordMode(wordMode),
    .swapA   (swapA),
    .swapB   (swapB),
    .carryIn (carryIn),
    .ctrl    (ctrl),
    .result  (result),
    .flags   (flags)
  );

  assign flagWe = ctrl.flagWe;

  logic [LANE_W-1:0] hiOfA;
  logic [DATA_W-1:0] exB;
  assign hiOfA = swapA ? opA[LANE_W-1:0] : opA[DATA_W-1:LANE_W];
  assign exB   = swapB ? {opB[LANE_W-1:0], opB[DATA_W-1:LANE_W]} : opB;

  always_comb begin
    // R6
    if (!wordMode && flagWe)
      byte_upper_chk: assert (result[DATA_W-1:LANE_W] == hiOfA)
        else $error("byte mode upper byte not passed through");
    // R11
    if (!flagWe)
      pass_quiet_chk: assert (flags == '0 && result == exB)
        else $error("pass operation touched flags or result");
    // R4
    if (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR || opCode == OP_BIT)
      logic_carry_chk: assert (flags[CC_C] == carryIn && !flags[CC_V] && !flags[CC_H])
        else $error("logic operation changed C, V or H");
    // R5
    if (opCode == OP_BIT)
      bit_keep_chk: assert (flagWe && result == (swapA ? {opA[LANE_W-1:0], opA[DATA_W-1:LANE_W]} : opA))
        else $error("bit test altered the result or dropped flag write");
  end

endmodule

// File: tb/alu16_lanes_tb_top.sv
module alu16_lanes_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] opA = '0, opB = '0;
  logic [3:0]  opCode = '0;
  logic        wordMode = 1'b0, swapA = 1'b0, swapB = 1'b0, carryIn = 1'b0;
  logic [15:0] result;
  logic [7:0]  flags;
  logic        flagWe;

  alu16_lanes dut_i (
    .opA(opA), .opB(opB), .opCode(opCode), .wordMode(wordMode),
    .swapA(swapA), .swapB(swapB), .carryIn(carryIn),
    .result(result), .flags(flags), .flagWe(flagWe)
  );

  typedef struct {
    logic [15:0] expR;
    logic [7:0]  expF;
    logic        expWe;
    string       tag;
  } expItem_t;

  expItem_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference built from the requirement text
  function automatic void model(input logic [15:0] a, input logic [15:0] b, input logic [3:0] op,
                                input logic w, input logic sa, input logic sb, input logic ci,
                                output logic [15:0] r, output logic [7:0] f, output logic we);
    logic [15:0] xa, xb, mask, bb, val;
    logic [16:0] tot;
    logic [4:0]  nib;
    logic        arith, sub, cin, n, z, v, c, h;
    int          msb;
    xa = sa ? {a[7:0], a[15:8]} : a;
    xb = sb ? {b[7:0], b[15:8]} : b;
    if (op == 4'd0 || op > 4'd8) begin // R11
      r = xb; f = 8'h00; we = 1'b0;
      return;
    end
    we    = 1'b1;
    mask  = w ? 16'hFFFF : 16'h00FF;
    msb   = w ? 15 : 7;
    arith = (op >= 4'd1 && op <= 4'd4);
    sub   = (op == 4'd3 || op == 4'd4);
    cin   = (op == 4'd2) ? ci : (op == 4'd3) ? 1'b1 : (op == 4'd4) ? ~ci : 1'b0;
    bb    = sub ? (~xb & mask) : (xb & mask);
    tot   = {1'b0, xa & mask} + {1'b0, bb} + {16'b0, cin};
    case (op)
      4'd5, 4'd8: val = xa & xb;
      4'd6:       val = xa | xb;
      4'd7:       val = xa ^ xb;
      default:    val = tot[15:0];
    endcase
    val = val & mask;
    n = val[msb];
    z = (val == 16'h0);
    if (arith) begin
      c = tot[msb+1] ^ sub;
      v = (xa[msb] == bb[msb]) && (val[msb] != xa[msb]);
    end else begin
      c = ci; v = 1'b0;
    end
    nib = {1'b0, xa[3:0]} + {1'b0, bb[3:0]} + {4'b0, cin};
    h = (op == 4'd1 || op == 4'd2) ? nib[4] : 1'b0;
    f = {3'b000, h, n, z, v, c}; // R10 layout
    r = (op == 4'd8) ? xa : (w ? val : {xa[15:8], val[7:0]});
  endfunction

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [3:0] op,
                       input logic w, input logic sa, input logic sb, input logic ci, input string tag);
    expItem_t it;
    @(posedge clk);
    #1;
    opA = a; opB = b; opCode = op; wordMode = w; swapA = sa; swapB = sb; carryIn = ci;
    model(a, b, op, w, sa, sb, ci, it.expR, it.expF, it.expWe);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: results due in the same period, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      expItem_t it;
      it = q.pop_front();
      checks++;
      if (result !== it.expR) begin
        fails++;
        $display("FAIL %s result: got %h expected %h", it.tag, result, it.expR);
      end
      checks++;
      if (flags !== it.expF) begin
        fails++;
        $display("FAIL %s flags: got %h expected %h", it.tag, flags, it.expF);
      end
      checks++;
      if (flagWe !== it.expWe) begin
        fails++;
        $display("FAIL %s flagWe: got %b expected %b", it.tag, flagWe, it.expWe);
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(16'h0000, 16'h0000, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 reset-state pass");
    // R2 word adds: byte-boundary carry, overflow, wrap to zero
    drive(16'h00FF, 16'h0001, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R9 chain carry");
    drive(16'h7FFF, 16'h0001, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R8 overflow");
    drive(16'hFFFF, 16'h0001, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R8 wrap zero");
    drive(16'h1234, 16'h0FFF, 4'd2, 1'b1, 1'b0, 1'b0, 1'b1, "R2 adc carry in");
    // R3 subtracts
    drive(16'h0000, 16'h0001, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R3 borrow");
    drive(16'h8000, 16'h0001, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R3 R8 sub overflow");
    drive(16'h0100, 16'h0000, 4'd4, 1'b1, 1'b0, 1'b0, 1'b1, "R3 sbc borrow across byte");
    drive(16'h0005, 16'h0005, 4'd4, 1'b1, 1'b0, 1'b0, 1'b0, "R3 sbc zero");
    // R4 logic ops, carry passes through
    drive(16'hF0F0, 16'h0FF0, 4'd5, 1'b1, 1'b0, 1'b0, 1'b1, "R4 and");
    drive(16'hF000, 16'h0F0F, 4'd6, 1'b1, 1'b0, 1'b0, 1'b0, "R4 or");
    drive(16'hAAAA, 16'hAAAA, 4'd7, 1'b1, 1'b0, 1'b0, 1'b1, "R4 xor zero");
    // R5 bit test
    drive(16'h8001, 16'h8000, 4'd8, 1'b1, 1'b0, 1'b0, 1'b1, "R5 bit word");
    drive(16'h12F0, 16'h000F, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, "R5 bit byte zero");
    // R6 R7 byte mode with each swap choice
    drive(16'hAB7F, 16'hCD01, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 R7 byte overflow");
    drive(16'h7FAB, 16'h01CD, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R1 R6 swapped byte");
    drive(16'h55FF, 16'h0001, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 byte carry no ripple");
    drive(16'h3400, 16'h0100, 4'd3, 1'b0, 1'b0, 1'b1, 1'b0, "R1 R7 byte borrow swapB");
    drive(16'h0012, 16'h3400, 4'd6, 1'b0, 1'b1, 1'b1, 1'b1, "R1 R6 byte or swap both");
    // R1 word endianness
    drive(16'h0102, 16'h0304, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, "R1 word swapA");
    drive(16'h0102, 16'h0304, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0, "R1 word swapB");
    // R9 nibble carry only in add forms
    drive(16'h000F, 16'h0001, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 half byte add");
    drive(16'h0010, 16'h0001, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R9 no half on sub");
    // R11 pass and unused codes
    drive(16'hDEAD, 16'hBEEF, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R11 pass swapped B");
    for (int k = 9; k < 16; k++)
      drive(16'h1111 * k[15:0], 16'hFFFF, 4'(k), 1'b0, 1'b0, 1'b0, 1'b1, "R11 unused code");
    // mixed stream
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr[15:0] ^ lfsr[31:16];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr[31:16];
      drive(ra, rb, 4'(lfsr[3:0] % 10), lfsr[4], lfsr[5], lfsr[6], lfsr[7], "R1 R2 R3 R8 random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule